// File: doc/BRIEF.md
# History-Keyed Indirect Branch Target Predictor

This block sits beside a conventional branch target buffer in a fetch pipeline. It keeps a small tagged table of targets for indirect jumps. The table is keyed by the global branch history mixed with the branch address. The same jump can therefore be given different targets depending on the path that led to it. On each lookup, the buffer's target is passed through unchanged unless two things are true: the buffer says the branch is an indirect jump, and the table holds a matching entry. In that case the table's target replaces the buffer's target.

Entries are created lazily. An indirect jump starts out predicted by the buffer alone. The back end sends a resolve report each time an indirect jump resolves. Only a report flagged as a target misprediction writes the table, and it writes under the history that led to that instance. A jump whose target depends on data therefore collects one entry per distinct history. The table is direct-mapped by the hashed index, so a later miss on the same slot displaces the earlier owner. Lookup is combinational. Resolve writes land on the next rising clock edge.

Top module: `indirect_target_predictor`

## Requirements
- R1: The hash is the address bits [ADDR_LSB +: HASH_W] XORed with the history, where history bit i is XORed into hash bit i mod HASH_W and HASH_W = IDX_W + TAG_W. The low IDX_W hash bits select the entry and the upper TAG_W bits are compared with the stored tag. A valid entry whose tag differs does not hit.
- R2: When btbHit and btbIndirect are both 1 and the selected entry is valid with a matching tag, predTarget equals the stored target.
- R3: In every other case, including a table hit with btbIndirect at 0 or btbHit at 0, predTarget equals btbTarget.
- R4: The table changes only on a cycle with both resValid and resMispredict at 1. A resolve report with resMispredict at 0, or resMispredict at 1 while resValid is 0, leaves every later lookup result unchanged.
- R5: After a resolve report with both flags at 1 misses in the table, the entry selected by (resAddr, resHist) becomes valid with that tag and with resTarget as its target.
- R6: A mispredicted resolve report that hits an existing entry overwrites that entry's target with resTarget.
- R7: One address seen under different histories that map to different entries keeps a separate target per history.
- R8: A write to an entry whose tag belongs to another hash replaces it. The earlier key then no longer hits.
- R9: While rstN is 0, all entries are invalidated on each rising clock edge. After reset, every lookup returns btbTarget until a new write occurs.
- R10: A write becomes visible to lookups from the cycle after the resolve edge. A lookup in the same cycle as the write sees the earlier contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| lkAddr | input | ADDR_W | Branch address being looked up |
| lkHist | input | HIST_W | Global history at lookup |
| btbHit | input | 1 | Target buffer hit for this address |
| btbIndirect | input | 1 | Target buffer marks the branch as indirect |
| btbTarget | input | ADDR_W | Target predicted by the buffer |
| predTarget | output | ADDR_W | Final predicted target |
| resValid | input | 1 | A resolved indirect jump is reported this cycle |
| resAddr | input | ADDR_W | Address of the resolved jump |
| resHist | input | HIST_W | History that preceded the resolved instance |
| resTarget | input | ADDR_W | Actual target of the resolved jump |
| resMispredict | input | 1 | The predicted target was wrong |

## Verification
A directed sequence covers the following cases. It allocates under one history and then reads back under that history with the indirect flag set and cleared, and with the buffer missing, to separate the override from the pass-through. A second history for the same address, and a key that shares the index but has a different tag, separate a per-history entry from a tag mismatch and from direct-mapped replacement. Resolve reports that are correct, or that are not valid, are followed by lookups, which show that the table did not change. A lookup in the same cycle as a write shows whether the write landed early. A random phase then draws addresses and histories from small pools, so that hits, aliasing and overwrites recur often. It is compared every cycle against a behavioural model.

// File: rtl/ibtp_pkg.sv
package ibtp_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic wrEn;    // write the resolve key/target into the table
    logic useAlt;  // select the table target over the buffer target
  } ibtpStrobes_t;
endpackage

// File: rtl/ibtp_control.sv
module ibtp_control
  import ibtp_pkg::*;
(
  input  logic         btbHit,
  input  logic         btbIndirect,
  input  logic         tableHit,
  input  logic         resValid,
  input  logic         resMispredict,
  output ibtpStrobes_t strobes
);
  logic overrideOk;
  logic allocReq;

  always_comb begin
    overrideOk = btbHit && btbIndirect;
    allocReq   = resValid && resMispredict;
    strobes.useAlt = overrideOk && tableHit;
    strobes.wrEn   = allocReq;
  end
endmodule

// File: rtl/ibtp_datapath.sv
module ibtp_datapath
  import ibtp_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int HIST_W   = 12,
  parameter int IDX_W    = 6,
  parameter int TAG_W    = 6,
  parameter int ADDR_LSB = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] lkAddr,
  input  logic [HIST_W-1:0] lkHist,
  input  logic [ADDR_W-1:0] btbTarget,
  input  logic [ADDR_W-1:0] resAddr,
  input  logic [HIST_W-1:0] resHist,
  input  logic [ADDR_W-1:0] resTarget,
  input  ibtpStrobes_t      strobes,
  output logic              tableHit,
  output logic [ADDR_W-1:0] predTarget
);
  localparam int HASH_W = IDX_W + TAG_W;
  localparam int DEPTH  = 1 << IDX_W;

  function automatic logic [HASH_W-1:0] hashKey(input logic [ADDR_W-1:0] a,
                                                input logic [HIST_W-1:0] h);
    logic [HASH_W-1:0] k;
    k = a[ADDR_LSB +: HASH_W];
    for (int i = 0; i < HIST_W; i++) begin
      k[i % HASH_W] = k[i % HASH_W] ^ h[i];
    end
    return k;
  endfunction

  logic [DEPTH-1:0]  validVec;
  logic [TAG_W-1:0]  tagMem [DEPTH];
  logic [ADDR_W-1:0] tgtMem [DEPTH];

  logic [HASH_W-1:0] lkKey, wrKey;
  logic [IDX_W-1:0]  lkIdx, wrIdx;
  logic [TAG_W-1:0]  lkTag, wrTag;

  always_comb begin
    lkKey = hashKey(lkAddr, lkHist);
    wrKey = hashKey(resAddr, resHist);
    lkIdx = lkKey[IDX_W-1:0];
    lkTag = lkKey[HASH_W-1:IDX_W];
    wrIdx = wrKey[IDX_W-1:0];
    wrTag = wrKey[HASH_W-1:IDX_W];
  end

  // Read side
  always_comb begin
    tableHit   = validVec[lkIdx] && (tagMem[lkIdx] == lkTag);
    predTarget = strobes.useAlt ? tgtMem[lkIdx] : btbTarget;
  end

  // Valid bits: cleared by reset, set on write
  always_ff @(posedge clk) begin
    if (!rstN) begin
      validVec <= '0;
    end else if (strobes.wrEn) begin
      validVec[wrIdx] <= 1'b1;
    end
  end

  // Tag and target storage, one slot per entry
  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (strobes.wrEn && (wrIdx == IDX_W'(e))) begin
        tagMem[e] <= wrTag;
        tgtMem[e] <= resTarget;
      end
    end
  end

  // R9: reset leaves every entry invalid
  p_reset_clear_r9: assert property (@(posedge clk)
    !rstN |=> (validVec == '0));

  // R4: no write strobe, no change to valid bits
  p_quiet_table_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrEn |=> $stable(validVec));

  // R5: written entry is valid afterwards
  p_write_sets_valid_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrEn |=> validVec[$past(wrIdx)]);

  // R6: written entry holds the resolved target
  p_target_written_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrEn |=> (tgtMem[$past(wrIdx)] == $past(resTarget)));
endmodule

// File: rtl/indirect_target_predictor.sv
module indirect_target_predictor
  import ibtp_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int HIST_W   = 12,
  parameter int IDX_W    = 6,
  parameter int TAG_W    = 6,
  parameter int ADDR_LSB = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] lkAddr,
  input  logic [HIST_W-1:0] lkHist,
  input  logic              btbHit,
  input  logic              btbIndirect,
  input  logic [ADDR_W-1:0] btbTarget,
  output logic [ADDR_W-1:0] predTarget,
  input  logic              resValid,
  input  logic [ADDR_W-1:0] resAddr,
  input  logic [HIST_W-1:0] resHist,
  input  logic [ADDR_W-1:0] resTarget,
  input  logic              resMispredict
);
  ibtpStrobes_t strobes;
  logic         tableHit;

  ibtp_control u_ctrl (
    .btbHit        (btbHit),
    .btbIndirect   (btbIndirect),
    .tableHit      (tableHit),
    .resValid      (resValid),
    .resMispredict (resMispredict),
    .strobes       (strobes)
  );

  ibtp_datapath #(
    .ADDR_W   (ADDR_W),
    .HIST_W   (HIST_W),
    .IDX_W    (IDX_W),
    .TAG_W    (TAG_W),
    .ADDR_LSB (ADDR_LSB)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .lkAddr     (lkAddr),
    .lkHist     (lkHist),
    .btbTarget  (btbTarget),
    .resAddr    (resAddr),
    .resHist    (resHist),
    .resTarget  (resTarget),
    .strobes    (strobes),
    .tableHit   (tableHit),
    .predTarget (predTarget)
  );

  // R3: the output departs from the buffer target only for a buffer-hit indirect jump
  p_override_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    (predTarget != btbTarget) |-> (btbHit && btbIndirect));
endmodule

// File: tb/indirect_target_predictor_tb.sv
module indirect_target_predictor_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] lkAddr = '0;
  logic [11:0] lkHist = '0;
  logic        btbHit = 1'b0;
  logic        btbIndirect = 1'b0;
  logic [31:0] btbTarget = '0;
  logic [31:0] predTarget;
  logic        resValid = 1'b0;
  logic [31:0] resAddr = '0;
  logic [11:0] resHist = '0;
  logic [31:0] resTarget = '0;
  logic        resMispredict = 1'b0;

  int checks = 0;
  int fails  = 0;

  // Behavioural model: slot -> (valid, tag, target)
  bit          mValid [int];
  int          mTag   [int];
  logic [31:0] mTgt   [int];

  always #2 clk = ~clk;

  indirect_target_predictor u_dut (
    .clk(clk), .rstN(rstN), .lkAddr(lkAddr), .lkHist(lkHist),
    .btbHit(btbHit), .btbIndirect(btbIndirect), .btbTarget(btbTarget),
    .predTarget(predTarget), .resValid(resValid), .resAddr(resAddr),
    .resHist(resHist), .resTarget(resTarget), .resMispredict(resMispredict)
  );

  function automatic int keyOf(input logic [31:0] a, input logic [11:0] h);
    return int'((a >> 2) & 32'hFFF) ^ int'(h);
  endfunction

  function automatic logic [31:0] expect_target();
    int k, slot, tg;
    k = keyOf(lkAddr, lkHist);
    slot = k % 64;
    tg = k / 64;
    if (btbHit && btbIndirect && mValid.exists(slot) && mValid[slot] && mTag[slot] == tg)
      return mTgt[slot];
    return btbTarget;
  endfunction

  task automatic step(input logic [31:0] a, input logic [11:0] h, input logic bh,
                      input logic bi, input logic [31:0] bt, input logic rv,
                      input logic [31:0] ra, input logic [11:0] rh,
                      input logic [31:0] rt, input logic rm, input string req);
    logic [31:0] exp;
    int k;
    @(negedge clk);
    lkAddr = a; lkHist = h; btbHit = bh; btbIndirect = bi; btbTarget = bt;
    resValid = rv; resAddr = ra; resHist = rh; resTarget = rt; resMispredict = rm;
    #1;
    exp = expect_target();
    checks++;
    if (predTarget !== exp) begin
      fails++;
      $display("FAIL %s: predTarget=%h expected=%h", req, predTarget, exp);
    end
    @(posedge clk);
    if (rstN && rv && rm) begin
      k = keyOf(ra, rh);
      mValid[k % 64] = 1'b1;
      mTag[k % 64]   = k / 64;
      mTgt[k % 64]   = rt;
    end
  endtask

  task automatic look(input logic [31:0] a, input logic [11:0] h, input logic bh,
                      input logic bi, input logic [31:0] bt, input string req);
    step(a, h, bh, bi, bt, 1'b0, '0, '0, '0, 1'b0, req);
  endtask

  task automatic resolve(input logic [31:0] a, input logic [11:0] h,
                         input logic [31:0] t, input logic rv, input logic rm, input string req);
    step(a, h, 1'b1, 1'b1, 32'hBBBB_0000, rv, a, h, t, rm, req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rstN = 1'b0;
    resValid = 1'b0;
    repeat (2) @(posedge clk);
    mValid.delete();
    @(negedge clk);
    rstN = 1'b1;
  endtask

  localparam logic [31:0] A  = 32'h0000_4A10;
  localparam logic [11:0] H1 = 12'h0A5;
  localparam logic [11:0] H2 = 12'h3C3;
  localparam logic [11:0] H3 = 12'h111;

  initial begin
    // R9: lookups during reset
    look(A, H1, 1'b1, 1'b1, 32'h1000_0000, "R9");
    do_reset();
    // R3: indirect lookup on empty table
    look(A, H1, 1'b1, 1'b1, 32'h1000_0004, "R3");
    // R10: write and same-cycle lookup of the same key
    step(A, H1, 1'b1, 1'b1, 32'h1000_0008, 1'b1, A, H1, 32'hCAFE_0100, 1'b1, "R10");
    // R5, R2: allocated entry overrides
    look(A, H1, 1'b1, 1'b1, 32'h1000_000C, "R5");
    look(A, H1, 1'b1, 1'b1, 32'h1000_0010, "R2");
    // R3: not indirect, buffer miss
    look(A, H1, 1'b1, 1'b0, 32'h1000_0014, "R3");
    look(A, H1, 1'b0, 1'b1, 32'h1000_0018, "R3");
    // R1: same slot, different tag does not hit
    look(A, H1 ^ 12'h040, 1'b1, 1'b1, 32'h1000_001C, "R1");
    // R7: second history for the same address
    resolve(A, H2, 32'hCAFE_0200, 1'b1, 1'b1, "R7");
    look(A, H1, 1'b1, 1'b1, 32'h1000_0020, "R7");
    look(A, H2, 1'b1, 1'b1, 32'h1000_0024, "R7");
    // R4: correct or invalid reports do not write
    resolve(A, H3, 32'hCAFE_0300, 1'b1, 1'b0, "R4");
    look(A, H3, 1'b1, 1'b1, 32'h1000_0028, "R4");
    resolve(A, H3, 32'hCAFE_0301, 1'b0, 1'b1, "R4");
    look(A, H3, 1'b1, 1'b1, 32'h1000_002C, "R4");
    resolve(A, H1, 32'hDEAD_0000, 1'b1, 1'b0, "R4");
    look(A, H1, 1'b1, 1'b1, 32'h1000_0030, "R4");
    // R6: overwrite a hit whose target was wrong
    resolve(A, H1, 32'hCAFE_0111, 1'b1, 1'b1, "R6");
    look(A, H1, 1'b1, 1'b1, 32'h1000_0034, "R6");
    // R8: conflicting key replaces the slot
    resolve(A, H1 ^ 12'h040, 32'hCAFE_0400, 1'b1, 1'b1, "R8");
    look(A, H1, 1'b1, 1'b1, 32'h1000_0038, "R8");
    look(A, H1 ^ 12'h040, 1'b1, 1'b1, 32'h1000_003C, "R8");
    // R9: reset mid-run invalidates all
    do_reset();
    look(A, H2, 1'b1, 1'b1, 32'h1000_0040, "R9");
    look(A, H1 ^ 12'h040, 1'b1, 1'b1, 32'h1000_0044, "R9");
    // Random phase over small pools
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] a, ra;
      logic [11:0] h, rh;
      a  = 32'h0000_4000 + 32'((($urandom % 4)) * 4 * 64);
      ra = 32'h0000_4000 + 32'((($urandom % 4)) * 4 * 64);
      h  = 12'(($urandom % 8) * 12'h041);
      rh = 12'(($urandom % 8) * 12'h041);
      step(a, h, 1'($urandom % 4 != 0), 1'($urandom % 4 != 0), $urandom,
           1'($urandom % 2), ra, rh, $urandom, 1'($urandom % 3 == 0), "R2/R3");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule